// File: doc/BRIEF.md
# Serial Population Counter

This block finds how many bits are set in a data word. It examines one bit per clock. A right-shifting operand register gives up its least significant bit each compute cycle, and a tally register adds that bit to the running count. The work ends as soon as the operand register holds nothing but zeros. A word whose highest set bit sits low in the word therefore finishes early. It does not always take the full word width in cycles.

The block is controlled through a handshake driven by the level of `mode`. While `mode` is low, the block sits idle. In this state the caller may place a word into the operand register with the `load` strobe, and the tally is held at zero. Raising `mode` starts the computation. When the computation finishes, `done` goes high and `count` holds the result for as long as `mode` stays high. Dropping `mode` returns the block to idle.

Top module: `popcount_serial`

## Requirements
- R1: An active-low `rst_n` acts at once, without waiting for a clock edge. It forces the block to idle with `done` = 0, `count` = 0 and an all-zero operand register.
- R2: In idle with `mode` = 0, `load` = 1 makes the operand register take `din` at the next rising edge. In idle, a cycle with `load` = 0 leaves the operand register unchanged, whatever `din` carries.
- R3: Every rising edge taken in idle clears `count` to 0.
- R4: In idle, `mode` = 1 moves the block to compute at the next rising edge. On that edge `load` is ignored, even if it is high.
- R5: On each compute edge with a non-zero operand, two things happen on the same edge. `count` grows by the operand's bit 0 as it stood before the edge, and the operand shifts right by one, with a 0 entering at the top. `load` and `mode` have no effect during compute.
- R6: A compute edge that finds the operand at zero ends the computation and raises `done`. Let L be the position of the highest set bit plus one, with L = 0 for a zero word. Then `done` is first seen high L+2 rising edges after the edge that samples `mode` = 1 in idle. A zero word therefore finishes after 2 edges with `count` = 0.
- R7: At `done`, `count` equals the number of set bits in the loaded word. `count` is $clog2(DATA_W+1) bits wide, so an all-ones word reads exactly DATA_W.
- R8: While `done` is high and `mode` stays 1, `done` stays high and `count` does not change. The first edge with `mode` = 0 drops `done` and returns the block to idle.
- R9: `load` is ignored in the done state. The operand is left empty after a computation, so a following computation run without a new load reports `count` = 0 after 2 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DATA_W | Word to be counted |
| load | input | 1 | Strobe that loads the operand while idle and `mode` is 0 |
| mode | input | 1 | 0 = load or read back, 1 = compute |
| count | output | $clog2(DATA_W+1) | Number of set bits found |
| done | output | 1 | Result ready, held while `mode` stays 1 |

## Verification
The bench builds the block with DATA_W = 12. At this width the count field is four bits wide and the all-ones result (12) is not a power of two, so an off-by-one in the width calculation shows up. The width is also narrow enough that random words cover every highest-set-bit position from 0 to 11, and with it every early-exit latency the loop can take. Directed words cover the zero word, a lone top bit, a lone bottom bit and all ones. They also cover load pulses during compute and done, and a reset applied in the middle of a computation.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic [1:0] {
        PC_IDLE = 2'd0,
        PC_RUN  = 2'd1,
        PC_FIN  = 2'd2
    } pc_state_e;

    typedef struct packed {
        logic load_en;
        logic shift_en;
        logic cnt_clr;
        logic cnt_en;
        logic done;
    } pc_ctrl_t;

endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
    import pcnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode,
    input  logic      load,
    input  logic      opnd_zero,
    output pc_ctrl_t  ctrl,
    output pc_state_e state
);

    typedef struct packed {
        pc_state_e st;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    pc_ctrl_t  c_d;

    always_comb begin
        r_d = r_q;
        c_d = '0;
        unique case (r_q.st)
            PC_IDLE: begin
                c_d.cnt_clr = 1'b1;
                c_d.load_en = load & ~mode;
                if (mode) r_d.st = PC_RUN;
            end
            PC_RUN: begin
                if (opnd_zero) begin
                    r_d.st = PC_FIN;
                end else begin
                    c_d.shift_en = 1'b1;
                    c_d.cnt_en   = 1'b1;
                end
            end
            PC_FIN: begin
                c_d.done = 1'b1;
                if (!mode) r_d.st = PC_IDLE;
            end
            default: r_d.st = PC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PC_IDLE};
        else        r_q <= r_d;
    end

    assign ctrl  = c_d;
    assign state = r_q.st;

endmodule

// File: rtl/pcnt_opnd.sv
module pcnt_opnd #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] opnd,
    output logic              lsb,
    output logic              zero
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } opnd_reg_t;

    opnd_reg_t r_d, r_q;

    // per-bit next-value selection: load, shift from the neighbour above, or hold
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic upper;
        if (i == DATA_W - 1) begin : g_top
            assign upper = 1'b0;
        end else begin : g_mid
            assign upper = r_q.word[i+1];
        end
        always_comb begin
            if (load_en)       r_d.word[i] = din[i];
            else if (shift_en) r_d.word[i] = upper;
            else               r_d.word[i] = r_q.word[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign opnd = r_q.word;
    assign lsb  = r_q.word[0];
    assign zero = ~|r_q.word;

endmodule

// File: rtl/pcnt_tally.sv
module pcnt_tally #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_reg_t;

    tally_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr)     r_d.cnt = '0;
        else if (en) r_d.cnt = r_q.cnt + {{(CNT_W-1){1'b0}}, bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count = r_q.cnt;

endmodule

// File: rtl/popcount_serial.sv
module popcount_serial #(
    parameter  int unsigned DATA_W = 16,
    localparam int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              load,
    input  logic              mode,
    output logic [CNT_W-1:0]  count,
    output logic              done
);

    import pcnt_pkg::*;

    pc_ctrl_t          ctrl;
    pc_state_e         st;
    logic [DATA_W-1:0] opnd;
    logic              opnd_lsb;
    logic              opnd_zero;

    pcnt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .load      (load),
        .opnd_zero (opnd_zero),
        .ctrl      (ctrl),
        .state     (st)
    );

    pcnt_opnd #(.DATA_W(DATA_W)) u_opnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ctrl.load_en),
        .shift_en (ctrl.shift_en),
        .din      (din),
        .opnd     (opnd),
        .lsb      (opnd_lsb),
        .zero     (opnd_zero)
    );

    pcnt_tally #(.CNT_W(CNT_W)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctrl.cnt_clr),
        .en     (ctrl.cnt_en),
        .bit_in (opnd_lsb),
        .count  (count)
    );

    assign done = ctrl.done;

endmodule

// File: rtl/popcount_serial_chk.sv
module popcount_serial_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode,
    input logic [CNT_W-1:0]  count,
    input logic              done,
    input logic [1:0]        state,
    input logic [DATA_W-1:0] opnd,
    input logic              opnd_zero
);

    localparam logic [1:0] S_IDLE = 2'd0;
    localparam logic [1:0] S_RUN  = 2'd1;
    localparam logic [1:0] S_FIN  = 2'd2;

    // R3
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> (count == '0));

    // R4
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && mode) |=> (state == S_RUN && $stable(opnd)));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !opnd_zero) |=>
        (count == $past(count) + {{(CNT_W-1){1'b0}}, $past(opnd[0])}));

    // R6
    exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && opnd_zero) |=> done);

    // R7
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(count) <= DATA_W));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode) |=> (done && $stable(count)));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode) |=> !done);

    // R9
    fin_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FIN) |=> $stable(opnd));

endmodule

bind popcount_serial popcount_serial_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .count     (count),
    .done      (done),
    .state     (st),
    .opnd      (opnd),
    .opnd_zero (opnd_zero)
);

// File: tb/tb_popcount_serial.sv
`timescale 1ns/1ps
module tb_popcount_serial;

    localparam int unsigned W  = 12;
    localparam int unsigned CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  din;
    logic          load;
    logic          mode;
    logic [CW-1:0] count;
    logic          done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    popcount_serial #(.DATA_W(W)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .load  (load),
        .mode  (mode),
        .count (count),
        .done  (done)
    );

    function automatic int popc(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int bitlen(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [W-1:0] v);
        @(negedge clk);
        load = 1'b1;
        din  = v;
        @(negedge clk);
        load = 1'b0;
        din  = W'($urandom);
        chk(count == '0, "R3 count cleared in idle", int'(count), 0);
        repeat (2) begin
            @(negedge clk);
            din = W'($urandom);
        end
    endtask

    // expects operand value v already in the block; junk drives load during compute
    task automatic compute(input logic [W-1:0] v, input bit junk);
        int cyc = 0;
        @(negedge clk);
        mode = 1'b1;
        if (junk) begin
            load = 1'b1;
            din  = ~v;
        end
        while (!done && cyc < W + 6) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (junk) din = W'($urandom);
        end
        load = 1'b0;
        chk(cyc == bitlen(v) + 2, "R6 latency to done", cyc, bitlen(v) + 2);
        chk(int'(count) == popc(v), junk ? "R5 count with load ignored" : "R7 count value",
            int'(count), popc(v));
        // hold phase with load pulses that must be ignored
        for (int k = 0; k < 3; k++) begin
            load = 1'b1;
            din  = W'($urandom) | W'(1);
            @(negedge clk);
            chk(done == 1'b1, "R8 done held", int'(done), 1);
            chk(int'(count) == popc(v), "R8 count stable", int'(count), popc(v));
        end
        load = 1'b0;
        mode = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R8 done drops", int'(done), 0);
        @(negedge clk);
        chk(count == '0, "R3 count cleared after release", int'(count), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        mode  = 1'b0;
        load  = 1'b0;
        din   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(count == '0, "R1 count at reset", int'(count), 0);
        rst_n = 1'b1;

        // R1: operand empty after reset, so a run with no load yields zero
        compute('0, 1'b0);

        // R7 directed corner words
        load_word({W{1'b1}});        compute({W{1'b1}}, 1'b0);
        load_word('0);               compute('0, 1'b0);
        load_word(W'(1) << (W - 1)); compute(W'(1) << (W - 1), 1'b0);
        load_word(W'(1));            compute(W'(1), 1'b0);
        load_word(W'(12'hAAA));      compute(W'(12'hAAA), 1'b0);

        // R2 / R4 / R5: load pulses at the start of and during compute
        load_word(W'(12'h5C3));      compute(W'(12'h5C3), 1'b1);

        // R9: load pulses during done (in compute) left operand empty
        compute('0, 1'b0);

        // R1: reset in the middle of a computation acts without a clock edge
        load_word({W{1'b1}});
        @(negedge clk);
        mode = 1'b1;
        repeat (4) @(negedge clk);
        #0.5 rst_n = 1'b0;
        #0.5;
        chk(count == '0, "R1 async count clear", int'(count), 0);
        chk(done == 1'b0, "R1 async done clear", int'(done), 0);
        mode = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        compute('0, 1'b0);

        // random words with and without load noise
        for (int t = 0; t < 150; t++) begin
            logic [W-1:0] v;
            v = W'($urandom);
            if (t % 7 == 0) v = v >> ($urandom % W);
            load_word(v);
            compute(v, (t % 3) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule